// File: doc/BRIEF.md
# Dual-Channel Command Decoder with Double-Buffered Code Registers

This block takes 16-bit command words from a serial receiver and keeps the digital side of a two-channel 12-bit converter. Each channel holds a staging (input) register and a live (output) register. The live register is what the analog stage converts. Commands can load a staging register, copy staging values into live registers, load all four registers at once, select the serial read-back clock edge, and send shutdown or power-down requests to a separate power controller.

Two asynchronous pins also act on the registers, and each passes through a synchronizer first. An active-low load pin copies both staging registers into the live registers. An active-low clear pin forces all four registers to a reset value. A strap pin picks that reset value: zero or midscale. The synchronous power-on reset uses the same reset value.

Command words arrive on a valid/ready stream. The block has no internal buffer. It takes a word in any cycle where both valid and ready are high, and it decodes and executes that word on the same clock edge. Ready goes low while reset is active and while the synchronized clear is active. A word offered during that time stays pending. The sender must keep it stable until ready returns or withdraw it.

Top module: `dacreg_cmd_top`

## Requirements
- R1: Under reset (`rst_n` low, synchronous), both live registers and both staging registers take the reset value: 0x000 when `mid_sel` is 0 and 0x800 when it is 1. `dout_mode` becomes 0 and `cmd_ready` is low.
- R2: The word layout is: bits [15:13] hold the opcode, bits [12:1] hold the data (bit 12 is the MSB), and bit 0 is the sub-bit. Opcode 001 writes the data to staging A and opcode 101 writes it to staging B. In both cases the live registers do not change.
- R3: Opcode 010 writes staging A and opcode 110 writes staging B. In the same edge, both live registers are copied from their staging registers, and the copy already includes the new value.
- R4: Opcode 011 writes the data into all four registers.
- R5: Opcode 100 copies both staging registers into the live registers. When the opcode is 000, bits [12:10] select an extended code. Code 001 copies staging A into live A only. Code 101 copies staging B into live B only.
- R6: Opcode 000 with extended code 100 sets `dout_mode` to bit 9 of the word. `dout_mode` holds that value until the next such word or a reset.
- R7: The first rising edge at which the 2-stage synchronizer shows `load_n` low copies both staging registers into the live registers. This is the third edge after `load_n` falls. The copy repeats on every edge while the pin stays low. If a staging write is accepted on the same edge, the copy uses the newly written value.
- R8: While the synchronized `clear_n` is low, all four registers are forced to the reset value selected by `mid_sel`. This takes effect at the third edge after the pin falls.
- R9: A word is ignored if its sub-bit is 1, or if its opcode is 000 with extended code 000 or 010. Ignored means that no register, no mode bit and no pulse changes.
- R10: Shutdown requests appear as one-cycle pulses in the cycle after the word is accepted. Opcode 111 pulses `pwr_shut`=11 with impedance A taken from bit 12 and impedance B from bit 11. Extended code 110 pulses shut A, and extended code 111 pulses shut B, each with its impedance taken from bit 9. Extended code 011 pulses `pwr_full_pd` together with `pwr_shut`=11, with impedance A from bit 9 and impedance B from bit 8. Bit 0 of the 2-bit power outputs is channel A.
- R11: `pwr_wake[c]` pulses for one cycle after an accepted word copies into live register c (opcodes 010, 011, 100 and 110, and extended codes 001 and 101). A copy triggered by the load pin produces no wake pulse.
- R12: `cmd_ready` is low while reset is active or the synchronized clear is active. A word offered while ready is low has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command word is offered |
| cmd_ready | output | 1 | The block can accept a word this cycle |
| cmd_word | input | 16 | Command word: opcode, data, sub-bit |
| load_n | input | 1 | Asynchronous active-low staging-to-live copy |
| clear_n | input | 1 | Asynchronous active-low clear to the reset value |
| mid_sel | input | 1 | Reset value select: 0 gives zero, 1 gives midscale |
| out_a | output | 12 | Live register of channel A |
| out_b | output | 12 | Live register of channel B |
| dout_mode | output | 1 | Read-back clock-edge mode |
| pwr_shut | output | 2 | Shutdown request pulse per channel |
| pwr_imp | output | 2 | Shutdown impedance select, valid with `pwr_shut` |
| pwr_full_pd | output | 1 | Full power-down request pulse |
| pwr_wake | output | 2 | Wake pulse per channel after a serial live update |

## Verification
The main sweep sends every combination of opcode, extended code and sub-bit, 128 words in all, each with a data pattern that depends on the word's own fields. Because the 128 words follow one another, each later copy shows what earlier writes left in the staging registers. This separates staging-only writes from live writes, and single-channel copies from dual-channel ones. A variant of the sweep changes only the sub-bit. It checks that a set sub-bit turns every opcode into a no-op, so the bit cannot be mistaken for a data bit. The pin tests run a load alone, a load held low while a staging write arrives, and clears under both straps. They also offer a word while ready is low. These cases separate the level-sensitive copy from the serial path and confirm that the reset value follows the strap.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;

  typedef enum logic [2:0] {
    OP_EXT      = 3'b000,
    OP_LD_A     = 3'b001,
    OP_LD_A_UPD = 3'b010,
    OP_LD_ALL   = 3'b011,
    OP_UPD_ALL  = 3'b100,
    OP_LD_B     = 3'b101,
    OP_LD_B_UPD = 3'b110,
    OP_SHUT_AB  = 3'b111
  } op_e;

  typedef enum logic [2:0] {
    XC_NONE0   = 3'b000,
    XC_UPD_A   = 3'b001,
    XC_NONE2   = 3'b010,
    XC_FULL_PD = 3'b011,
    XC_MODE    = 3'b100,
    XC_UPD_B   = 3'b101,
    XC_SHUT_A  = 3'b110,
    XC_SHUT_B  = 3'b111
  } xcode_e;

  // one decoded action, bit 0 of each pair is channel A
  typedef struct packed {
    logic [1:0] wr_stage;
    logic [1:0] copy_live;
    logic [1:0] shut;
    logic [1:0] imp;
    logic       full_pd;
    logic       mode_set;
    logic       mode_val;
  } act_t;

endpackage

// File: rtl/dacreg_sync.sv
module dacreg_sync #(
  parameter int          WIDTH   = 2,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] IDLE = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[s] <= IDLE;
          else        chain_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[s] <= IDLE;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/dacreg_decode.sv
module dacreg_decode
  import dacreg_pkg::*;
#(
  parameter int DW = 12,
  localparam int WW = DW + 4
) (
  input  logic [WW-1:0] word_i,
  input  logic          en_i,
  output act_t          act_o
);

  op_e    op;
  xcode_e xc;
  logic   sub_bit;
  logic   bit_hi, bit_nx, bit_x8, bit_x7;

  assign op      = op_e'(word_i[WW-1 -: 3]);
  assign xc      = xcode_e'(word_i[DW -: 3]);
  assign sub_bit = word_i[0];
  assign bit_hi  = word_i[DW];
  assign bit_nx  = word_i[DW-1];
  assign bit_x8  = word_i[DW-3];
  assign bit_x7  = word_i[DW-4];

  always_comb begin
    act_o = '0;
    if (en_i && !sub_bit) begin
      unique case (op)
        OP_LD_A:     act_o.wr_stage = 2'b01;
        OP_LD_B:     act_o.wr_stage = 2'b10;
        OP_LD_A_UPD: begin
          act_o.wr_stage  = 2'b01;
          act_o.copy_live = 2'b11;
        end
        OP_LD_B_UPD: begin
          act_o.wr_stage  = 2'b10;
          act_o.copy_live = 2'b11;
        end
        OP_LD_ALL: begin
          act_o.wr_stage  = 2'b11;
          act_o.copy_live = 2'b11;
        end
        OP_UPD_ALL:  act_o.copy_live = 2'b11;
        OP_SHUT_AB: begin
          act_o.shut = 2'b11;
          act_o.imp  = {bit_nx, bit_hi};
        end
        OP_EXT: begin
          unique case (xc)
            XC_UPD_A: act_o.copy_live = 2'b01;
            XC_UPD_B: act_o.copy_live = 2'b10;
            XC_MODE: begin
              act_o.mode_set = 1'b1;
              act_o.mode_val = bit_x8;
            end
            XC_SHUT_A: begin
              act_o.shut = 2'b01;
              act_o.imp  = {1'b0, bit_x8};
            end
            XC_SHUT_B: begin
              act_o.shut = 2'b10;
              act_o.imp  = {bit_x8, 1'b0};
            end
            XC_FULL_PD: begin
              act_o.full_pd = 1'b1;
              act_o.shut    = 2'b11;
              act_o.imp     = {bit_x7, bit_x8};
            end
            default: act_o = '0;
          endcase
        end
        default: act_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/dacreg_chan.sv
module dacreg_chan #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic [DW-1:0] rst_val_i,
  input  logic          wr_i,
  input  logic [DW-1:0] data_i,
  input  logic          copy_i,
  output logic [DW-1:0] live_o
);

  logic [DW-1:0] stage_q, stage_d, live_q;

  assign stage_d = wr_i ? data_i : stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      stage_q <= rst_val_i;
      live_q  <= rst_val_i;
    end else begin
      stage_q <= stage_d;
      if (copy_i) live_q <= stage_d;
    end
  end

  assign live_o = live_q;

endmodule

// File: rtl/dacreg_cmd_top.sv
module dacreg_cmd_top
  import dacreg_pkg::*;
#(
  parameter int DW          = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [DW+3:0] cmd_word,
  input  logic          load_n,
  input  logic          clear_n,
  input  logic          mid_sel,
  output logic [DW-1:0] out_a,
  output logic [DW-1:0] out_b,
  output logic          dout_mode,
  output logic [1:0]    pwr_shut,
  output logic [1:0]    pwr_imp,
  output logic          pwr_full_pd,
  output logic [1:0]    pwr_wake
);

  localparam int NCH = 2;
  localparam logic [DW-1:0] MID_CODE = {1'b1, {(DW-1){1'b0}}};

  logic [1:0]    pins_s;
  logic          load_act, clr_act, accept;
  logic [DW-1:0] rst_val;
  logic [DW-1:0] live [NCH];
  act_t          act;

  dacreg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .IDLE(2'b11)) pin_sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({load_n, clear_n}),
    .sync_o  (pins_s)
  );

  assign load_act  = ~pins_s[1];
  assign clr_act   = ~pins_s[0];
  assign cmd_ready = rst_n & ~clr_act;
  assign accept    = cmd_valid & cmd_ready;
  assign rst_val   = mid_sel ? MID_CODE : '0;

  dacreg_decode #(.DW(DW)) dec_i (
    .word_i (cmd_word),
    .en_i   (accept),
    .act_o  (act)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_chan
      dacreg_chan #(.DW(DW)) chan_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr_act),
        .rst_val_i (rst_val),
        .wr_i      (act.wr_stage[c]),
        .data_i    (cmd_word[DW:1]),
        .copy_i    (act.copy_live[c] | load_act),
        .live_o    (live[c])
      );
    end
  endgenerate

  assign out_a = live[0];
  assign out_b = live[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_shut    <= '0;
      pwr_imp     <= '0;
      pwr_full_pd <= 1'b0;
      pwr_wake    <= '0;
      dout_mode   <= 1'b0;
    end else begin
      pwr_shut    <= act.shut;
      pwr_imp     <= act.imp;
      pwr_full_pd <= act.full_pd;
      pwr_wake    <= act.copy_live;
      if (act.mode_set) dout_mode <= act.mode_val;
    end
  end

endmodule

// File: rtl/dacreg_chk.sv
module dacreg_chk #(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [DW+3:0] cmd_word,
  input logic          load_act,
  input logic          clr_act,
  input logic          mid_sel,
  input logic [DW-1:0] out_a,
  input logic [DW-1:0] out_b,
  input logic          dout_mode,
  input logic [1:0]    pwr_shut,
  input logic          pwr_full_pd,
  input logic [1:0]    pwr_wake
);

  localparam logic [DW-1:0] MID_CODE = {1'b1, {(DW-1){1'b0}}};

  logic       acc;
  logic [2:0] op;
  assign acc = cmd_valid && cmd_ready;
  assign op  = cmd_word[DW+3 -: 3];

  assert_stage_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (op == 3'b001 || op == 3'b101) && !cmd_word[0] && !load_act && !clr_act)
    |=> (out_a == $past(out_a) && out_b == $past(out_b)));

  assert_load_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == 3'b011 && !cmd_word[0] && !clr_act)
    |=> (out_a == $past(cmd_word[DW:1]) && out_b == $past(cmd_word[DW:1])));

  assert_clear_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |=> (out_a == ($past(mid_sel) ? MID_CODE : '0) &&
                 out_b == ($past(mid_sel) ? MID_CODE : '0)));

  assert_subbit_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_word[0] && !load_act && !clr_act)
    |=> (out_a == $past(out_a) && out_b == $past(out_b) && $stable(dout_mode)
         && pwr_shut == 2'b00 && !pwr_full_pd && pwr_wake == 2'b00));

  assert_full_pd_shuts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_full_pd |-> pwr_shut == 2'b11);

  assert_no_wake_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> pwr_wake == 2'b00);

  assert_stall_no_effect_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (pwr_shut == 2'b00 && pwr_wake == 2'b00 && $stable(dout_mode)));

endmodule

bind dacreg_cmd_top dacreg_chk #(.DW(DW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_word    (cmd_word),
  .load_act    (load_act),
  .clr_act     (clr_act),
  .mid_sel     (mid_sel),
  .out_a       (out_a),
  .out_b       (out_b),
  .dout_mode   (dout_mode),
  .pwr_shut    (pwr_shut),
  .pwr_full_pd (pwr_full_pd),
  .pwr_wake    (pwr_wake)
);

// File: tb/dacreg_cmd_top_tb_top.sv
module dacreg_cmd_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] cmd_word = '0;
  logic        load_n = 1'b1;
  logic        clear_n = 1'b1;
  logic        mid_sel = 1'b0;
  logic [11:0] out_a, out_b;
  logic        dout_mode;
  logic [1:0]  pwr_shut, pwr_imp, pwr_wake;
  logic        pwr_full_pd;

  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;

  // bench model
  logic [11:0] m_stage [2];
  logic [11:0] m_live [2];
  logic        m_mode;
  logic [1:0]  e_shut, e_imp, e_wake;
  logic        e_fpd;

  always #4 clk = ~clk;

  dacreg_cmd_top dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .load_n(load_n), .clear_n(clear_n), .mid_sel(mid_sel),
    .out_a(out_a), .out_b(out_b), .dout_mode(dout_mode), .pwr_shut(pwr_shut),
    .pwr_imp(pwr_imp), .pwr_full_pd(pwr_full_pd), .pwr_wake(pwr_wake)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  function automatic string tag_of(input logic [15:0] w);
    logic [2:0] op, xc;
    op = w[15:13];
    xc = w[12:10];
    if (w[0]) return "R9";
    case (op)
      3'b001, 3'b101: return "R2";
      3'b010, 3'b110: return "R3";
      3'b011: return "R4";
      3'b100: return "R5";
      3'b111: return "R10";
      default: begin
        case (xc)
          3'b001, 3'b101: return "R5";
          3'b100: return "R6";
          3'b011, 3'b110, 3'b111: return "R10";
          default: return "R9";
        endcase
      end
    endcase
  endfunction

  // expected effect of one accepted word
  task automatic model_word(input logic [15:0] w);
    logic [2:0]  op, xc;
    logic [11:0] d;
    logic [1:0]  wr, cp;
    op = w[15:13]; d = w[12:1]; xc = d[11:9];
    wr = 0; cp = 0; e_shut = 0; e_imp = 0; e_fpd = 0;
    if (!w[0]) begin
      case (op)
        3'b001: wr = 2'b01;
        3'b101: wr = 2'b10;
        3'b010: begin wr = 2'b01; cp = 2'b11; end
        3'b110: begin wr = 2'b10; cp = 2'b11; end
        3'b011: begin wr = 2'b11; cp = 2'b11; end
        3'b100: cp = 2'b11;
        3'b111: begin e_shut = 2'b11; e_imp = {d[10], d[11]}; end
        default: begin
          case (xc)
            3'b001: cp = 2'b01;
            3'b101: cp = 2'b10;
            3'b100: m_mode = d[8];
            3'b110: begin e_shut = 2'b01; e_imp = {1'b0, d[8]}; end
            3'b111: begin e_shut = 2'b10; e_imp = {d[8], 1'b0}; end
            3'b011: begin e_shut = 2'b11; e_fpd = 1'b1; e_imp = {d[7], d[8]}; end
            default: ;
          endcase
        end
      endcase
    end
    for (int c = 0; c < 2; c++) begin
      if (wr[c]) m_stage[c] = d;
      if (cp[c]) m_live[c] = m_stage[c];
    end
    e_wake = cp;
  endtask

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    cmd_word = w;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic send_and_check(input logic [15:0] w);
    string t;
    t = tag_of(w);
    send(w);
    model_word(w);
    check(t, "out_a", 32'(out_a), 32'(m_live[0]));
    check(t, "out_b", 32'(out_b), 32'(m_live[1]));
    check(t, "dout_mode", 32'(dout_mode), 32'(m_mode));
    check(t, "pwr_shut", 32'(pwr_shut), 32'(e_shut));
    check(t, "pwr_imp", 32'(pwr_imp & pwr_shut), 32'(e_imp));
    check(t, "pwr_full_pd", 32'(pwr_full_pd), 32'(e_fpd));
    check("R11", "pwr_wake", 32'(pwr_wake), 32'(e_wake));
  endtask

  task automatic do_reset(input logic mid);
    logic [11:0] rv;
    rv = mid ? 12'h800 : 12'h000;
    mid_sel = mid;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "cmd_ready in reset", 32'(cmd_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "out_a after reset", 32'(out_a), 32'(rv));
    check("R1", "out_b after reset", 32'(out_b), 32'(rv));
    check("R1", "dout_mode after reset", 32'(dout_mode), 0);
    for (int c = 0; c < 2; c++) begin m_stage[c] = rv; m_live[c] = rv; end
    m_mode = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 2; c++) begin m_stage[c] = 0; m_live[c] = 0; end
    m_mode = 0;
    do_reset(1'b0);

    // R2 R3 R4 R5 R6 R9 R10 sweep over all opcode / extended code / sub-bit combinations
    for (int sb = 0; sb < 2; sb++) begin
      for (int op = 0; op < 8; op++) begin
        for (int xc = 0; xc < 8; xc++) begin
          logic [8:0]  lo;
          logic [11:0] d;
          lo = 9'(((op * 37) + (sb * 91) + (xc * 13) + 5) * 29);
          d  = {3'(xc), lo};
          send_and_check({3'(op), d, 1'(sb)});
        end
      end
    end

    // R6 mode toggling both ways
    send_and_check({3'b000, 3'b100, 1'b1, 8'h00, 1'b0});
    send_and_check({3'b000, 3'b100, 1'b0, 8'hFF, 1'b0});

    // R7 load pin alone, then with a simultaneous staging write
    send_and_check({3'b001, 12'h123, 1'b0});
    send_and_check({3'b101, 12'h456, 1'b0});
    @(negedge clk);
    load_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R7", "out_a before sync completes", 32'(out_a), 32'(m_live[0]));
    @(negedge clk);
    check("R7", "out_a after load", 32'(out_a), 32'h123);
    check("R7", "out_b after load", 32'(out_b), 32'h456);
    check("R11", "no wake from load pin", 32'(pwr_wake), 0);
    m_live[0] = 12'h123; m_live[1] = 12'h456;
    send(16'h0000 | {3'b001, 12'h9AB, 1'b0});
    check("R7", "load copies same-edge write", 32'(out_a), 32'h9AB);
    check("R11", "no wake on staging write under load", 32'(pwr_wake), 0);
    m_stage[0] = 12'h9AB; m_live[0] = 12'h9AB;
    load_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8 and R12 clear to midscale, word offered while stalled
    mid_sel = 1'b1;
    clear_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R8", "out_a clear midscale", 32'(out_a), 32'h800);
    check("R8", "out_b clear midscale", 32'(out_b), 32'h800);
    check("R12", "ready low in clear", 32'(cmd_ready), 0);
    cmd_word = {3'b011, 12'h3C3, 1'b0};
    cmd_valid = 1'b1;
    repeat (2) @(negedge clk);
    check("R12", "stalled word no effect", 32'(out_a), 32'h800);
    check("R12", "stalled word no wake", 32'(pwr_wake), 0);
    cmd_valid = 1'b0;
    clear_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R12", "ready back after clear", 32'(cmd_ready), 1);
    for (int c = 0; c < 2; c++) begin m_stage[c] = 12'h800; m_live[c] = 12'h800; end
    send_and_check({3'b100, 12'h000, 1'b0});  // R8 staging cleared too
    send_and_check({3'b011, 12'h5A5, 1'b0});

    // R8 clear to zero
    mid_sel = 1'b0;
    clear_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R8", "out_a clear zero", 32'(out_a), 0);
    check("R8", "out_b clear zero", 32'(out_b), 0);
    clear_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int c = 0; c < 2; c++) begin m_stage[c] = 0; m_live[c] = 0; end
    send_and_check({3'b100, 12'h000, 1'b0});

    // R1 reset with midscale strap
    send_and_check({3'b000, 3'b100, 1'b1, 8'h00, 1'b0});
    do_reset(1'b1);
    send_and_check({3'b100, 12'h000, 1'b0});

    finish_run();
  end

endmodule